// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small pool of operand-holding slots that sits in front of a single functional unit in an out-of-order core. Each issued operation carries an opcode, the reorder-buffer index of its destination, and two sources. Each source arrives either as a ready value or as the reorder-buffer index of the instruction that will produce it. A slot that still waits on a source watches the shared result bus every cycle. When the tag on the bus matches, the slot takes the value.

When both sources of a slot hold values, the slot can be sent to the functional unit. If several slots are ready, the one with the lowest index goes first. A sent slot stays occupied until the bus carries the result tagged with that slot's destination index, and then the slot is free again. A flush input empties every slot at once. An operation enters only when a slot is free and the reorder buffer reports a free entry.

Top module: `resv_station`

## Requirements
- R1: After reset every slot is empty: `disp_valid` is 0 and `iss_ready` equals `rob_free`.
- R2: `iss_ready` is 1 only when at least one slot is free and `rob_free` is 1. An operation is accepted only in a cycle where `iss_valid` and `iss_ready` are both 1 and `flush` is 0, and it goes into the lowest-numbered free slot.
- R3: A slot holding a source that is not ready compares that source's tag with `bus_tag` in every cycle where `bus_valid` is 1. On a match it stores `bus_val` as the source value.
- R4: If the bus carries a matching tag in the same cycle that an operation is accepted with a non-ready source, that source is stored as ready with `bus_val`. The operation can then dispatch in the next cycle.
- R5: A slot is presented on the dispatch port (`disp_valid`=1, with its opcode, both source values and its destination index) only while both of its sources hold values. Each accepted operation is dispatched exactly once. An operation accepted with both sources ready is presented in the cycle right after acceptance.
- R6: When several slots are ready, the lowest-numbered one is dispatched, and `disp_slot` gives its index.
- R7: A dispatched slot stays occupied until a cycle in which `bus_valid` is 1 and `bus_tag` equals its destination index. It is free from the next cycle on.
- R8: With `flush` at 1, `disp_valid` is 0, no operation is accepted, and every slot is empty from the next cycle on. A later broadcast of a tag that the flushed slots waited on dispatches nothing.
- R9: With all 4 slots occupied, `iss_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty all slots |
| rob_free | input | 1 | Reorder buffer has a free entry |
| iss_valid | input | 1 | Operation offered for issue |
| iss_op | input | OP_W | Opcode |
| iss_dst | input | TAG_W | Destination reorder-buffer index |
| iss_a_rdy | input | 1 | Source A holds a value |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B holds a value |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| iss_ready | output | 1 | Issue can be accepted |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Result tag (reorder-buffer index) |
| bus_val | input | DATA_W | Result value |
| disp_valid | output | 1 | Operation sent to the functional unit |
| disp_slot | output | SLOT_IW | Index of the dispatched slot |
| disp_op | output | OP_W | Dispatched opcode |
| disp_a | output | DATA_W | Dispatched source A value |
| disp_b | output | DATA_W | Dispatched source B value |
| disp_dst | output | TAG_W | Dispatched destination index |

## Verification
Each issue and each bus capture takes effect at the next clock edge. So an operation that is accepted with both sources ready, or that captures its last source from the bus, is on the dispatch port in the following cycle. A slot freed by its own result raises `iss_ready` one cycle after that broadcast. The bench models a functional unit with a fixed 3-cycle latency: a result goes on the bus three cycles after the cycle in which its dispatch was sampled. The bench samples every output 2 ns after the falling edge, once the inputs driven at that edge have settled. It compares the dispatch port and `iss_ready` in that same cycle against a per-tag record and an occupancy count, and it updates both at the following rising edge.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_HOLD = 2'd1,
        SLOT_BUSY = 2'd2
    } slot_st_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     gnt
);

    // scan from the top so the lowest requesting index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                gnt = N'(1) << i;
            end
        end
    end

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic              fire,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic              ld_a_rdy,
    input  logic [DATA_W-1:0] ld_a_val,
    input  logic [TAG_W-1:0]  ld_a_tag,
    input  logic              ld_b_rdy,
    input  logic [DATA_W-1:0] ld_b_val,
    input  logic [TAG_W-1:0]  ld_b_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_val,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val,
    output logic [TAG_W-1:0]  dst
);

    typedef struct packed {
        slot_st_e          st;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic              a_ok;
        logic [DATA_W-1:0] a_v;
        logic [TAG_W-1:0]  a_t;
        logic              b_ok;
        logic [DATA_W-1:0] b_v;
        logic [TAG_W-1:0]  b_t;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.st == SLOT_HOLD) begin
            if (bus_valid && !slot_q.a_ok && slot_q.a_t == bus_tag) begin
                slot_d.a_ok = 1'b1;
                slot_d.a_v  = bus_val;
            end
            if (bus_valid && !slot_q.b_ok && slot_q.b_t == bus_tag) begin
                slot_d.b_ok = 1'b1;
                slot_d.b_v  = bus_val;
            end
            if (fire) begin
                slot_d.st = SLOT_BUSY;
            end
        end
        if (slot_q.st == SLOT_BUSY && bus_valid && bus_tag == slot_q.dst) begin
            slot_d.st = SLOT_IDLE;
        end
        if (load) begin
            slot_d.st   = SLOT_HOLD;
            slot_d.op   = ld_op;
            slot_d.dst  = ld_dst;
            slot_d.a_t  = ld_a_tag;
            slot_d.b_t  = ld_b_tag;
            slot_d.a_ok = ld_a_rdy | (bus_valid && ld_a_tag == bus_tag);
            slot_d.a_v  = ld_a_rdy ? ld_a_val : bus_val;
            slot_d.b_ok = ld_b_rdy | (bus_valid && ld_b_tag == bus_tag);
            slot_d.b_v  = ld_b_rdy ? ld_b_val : bus_val;
        end
        if (flush) begin
            slot_d.st = SLOT_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy  = (slot_q.st != SLOT_IDLE);
    assign ready = (slot_q.st == SLOT_HOLD) && slot_q.a_ok && slot_q.b_ok;
    assign op    = slot_q.op;
    assign a_val = slot_q.a_v;
    assign b_val = slot_q.b_v;
    assign dst   = slot_q.dst;

endmodule

// File: rtl/resv_station.sv
module resv_station #(
    parameter int NSLOT   = 4,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    parameter int OP_W    = 2,
    parameter int SLOT_IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               rob_free,
    input  logic               iss_valid,
    input  logic [OP_W-1:0]    iss_op,
    input  logic [TAG_W-1:0]   iss_dst,
    input  logic               iss_a_rdy,
    input  logic [DATA_W-1:0]  iss_a_val,
    input  logic [TAG_W-1:0]   iss_a_tag,
    input  logic               iss_b_rdy,
    input  logic [DATA_W-1:0]  iss_b_val,
    input  logic [TAG_W-1:0]   iss_b_tag,
    output logic               iss_ready,
    input  logic               bus_valid,
    input  logic [TAG_W-1:0]   bus_tag,
    input  logic [DATA_W-1:0]  bus_val,
    output logic               disp_valid,
    output logic [SLOT_IW-1:0] disp_slot,
    output logic [OP_W-1:0]    disp_op,
    output logic [DATA_W-1:0]  disp_a,
    output logic [DATA_W-1:0]  disp_b,
    output logic [TAG_W-1:0]   disp_dst
);

    logic [NSLOT-1:0]   busy_vec;
    logic [NSLOT-1:0]   rdy_vec;
    logic [NSLOT-1:0]   free_gnt;
    logic [NSLOT-1:0]   rdy_gnt;
    logic [NSLOT-1:0]   load_vec;
    logic [NSLOT-1:0]   fire_vec;
    logic               free_any;
    logic               rdy_any;
    logic [SLOT_IW-1:0] free_idx;
    logic [SLOT_IW-1:0] rdy_idx;
    logic               accept;

    logic [OP_W-1:0]   s_op  [NSLOT];
    logic [DATA_W-1:0] s_a   [NSLOT];
    logic [DATA_W-1:0] s_b   [NSLOT];
    logic [TAG_W-1:0]  s_dst [NSLOT];

    rs_pick #(.N(NSLOT), .IDX_W(SLOT_IW)) i_free_pick (
        .req (~busy_vec),
        .any (free_any),
        .idx (free_idx),
        .gnt (free_gnt)
    );

    rs_pick #(.N(NSLOT), .IDX_W(SLOT_IW)) i_rdy_pick (
        .req (rdy_vec),
        .any (rdy_any),
        .idx (rdy_idx),
        .gnt (rdy_gnt)
    );

    assign iss_ready  = free_any & rob_free;
    assign accept     = iss_valid & iss_ready & ~flush;
    assign load_vec   = accept ? free_gnt : '0;
    assign disp_valid = rdy_any & ~flush;
    assign fire_vec   = disp_valid ? rdy_gnt : '0;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .load      (load_vec[g]),
            .fire      (fire_vec[g]),
            .ld_op     (iss_op),
            .ld_dst    (iss_dst),
            .ld_a_rdy  (iss_a_rdy),
            .ld_a_val  (iss_a_val),
            .ld_a_tag  (iss_a_tag),
            .ld_b_rdy  (iss_b_rdy),
            .ld_b_val  (iss_b_val),
            .ld_b_tag  (iss_b_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_val   (bus_val),
            .busy      (busy_vec[g]),
            .ready     (rdy_vec[g]),
            .op        (s_op[g]),
            .a_val     (s_a[g]),
            .b_val     (s_b[g]),
            .dst       (s_dst[g])
        );
    end

    assign disp_slot = rdy_idx;
    assign disp_op   = s_op[rdy_idx];
    assign disp_a    = s_a[rdy_idx];
    assign disp_b    = s_b[rdy_idx];
    assign disp_dst  = s_dst[rdy_idx];

endmodule

module rs_chk #(
    parameter int NSLOT   = 4,
    parameter int SLOT_IW = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               rob_free,
    input logic               iss_ready,
    input logic               disp_valid,
    input logic [SLOT_IW-1:0] disp_slot,
    input logic [NSLOT-1:0]   busy_vec,
    input logic [NSLOT-1:0]   rdy_vec
);

    // R2
    rob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> rob_free);

    // R9
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) == NSLOT) |-> !iss_ready);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0));

    // R8
    flush_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !disp_valid);

    // R6
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((rdy_vec & ((NSLOT'(1) << disp_slot) - NSLOT'(1))) == '0));

    // R5
    once_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && disp_slot == $past(disp_slot)));

    // R5
    both_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> rdy_vec[disp_slot]);

endmodule

bind resv_station rs_chk #(.NSLOT(NSLOT), .SLOT_IW(SLOT_IW)) i_rs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .rob_free   (rob_free),
    .iss_ready  (iss_ready),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot),
    .busy_vec   (busy_vec),
    .rdy_vec    (rdy_vec)
);

// File: tb/test_resv_station.sv
module test_resv_station;

    localparam int NS  = 4;
    localparam int DW  = 32;
    localparam int TW  = 4;
    localparam int OW  = 2;
    localparam int SW  = 2;
    localparam int NT  = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          rob_free = 1'b1;
    logic          iss_valid = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic [TW-1:0] iss_dst = '0;
    logic          iss_a_rdy = 1'b0;
    logic [DW-1:0] iss_a_val = '0;
    logic [TW-1:0] iss_a_tag = '0;
    logic          iss_b_rdy = 1'b0;
    logic [DW-1:0] iss_b_val = '0;
    logic [TW-1:0] iss_b_tag = '0;
    logic          iss_ready;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [DW-1:0] bus_val = '0;
    logic          disp_valid;
    logic [SW-1:0] disp_slot;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a;
    logic [DW-1:0] disp_b;
    logic [TW-1:0] disp_dst;

    resv_station #(.NSLOT(NS), .DATA_W(DW), .TAG_W(TW), .OP_W(OW)) i_resv_station (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int occ    = 0;

    bit          rec_v [NT];
    bit          rec_disp [NT];
    bit          rec_ak [NT];
    bit          rec_bk [NT];
    logic [DW-1:0] rec_ae [NT];
    logic [DW-1:0] rec_be [NT];
    logic [TW-1:0] rec_at [NT];
    logic [TW-1:0] rec_bt [NT];
    logic [OW-1:0] rec_op [NT];
    bit          live [NT];
    bit          ext [NT];
    bit          fp_v [8];
    logic [TW-1:0] fp_t [8];
    logic [DW-1:0] fp_d [8];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] alu(input logic [OW-1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a ^ b;
            default: return a & b;
        endcase
    endfunction

    function automatic int free_tag();
        int s = int'($urandom % NT);
        for (int k = 0; k < NT; k++) begin
            if (!live[(s + k) % NT]) return (s + k) % NT;
        end
        return -1;
    endfunction

    function automatic int pend_tag(input bit ext_only);
        int s = int'($urandom % NT);
        for (int k = 0; k < NT; k++) begin
            int t = (s + k) % NT;
            if (live[t] && (!ext_only || ext[t])) return t;
        end
        return -1;
    endfunction

    task automatic clear_all();
        for (int t = 0; t < NT; t++) begin
            rec_v[t] = 0; rec_disp[t] = 0; live[t] = 0; ext[t] = 0;
        end
        for (int k = 0; k < 8; k++) fp_v[k] = 0;
        occ = 0;
    endtask

    task automatic tick();
        int t;
        bit accept;
        #2;
        // R2 / R7 / R9: occupancy model against iss_ready
        chk(iss_ready == ((occ < NS) && rob_free), (occ == NS) ? "R9 full blocks issue" : "R7 occupancy and R2 rob gate",
            {63'd0, iss_ready}, {63'd0, ((occ < NS) && rob_free)});
        if (flush) chk(!disp_valid, "R8 no dispatch during flush", {63'd0, disp_valid}, 64'd0);
        if (disp_valid) begin
            t = int'(disp_dst);
            chk(rec_v[t] && !rec_disp[t], "R5 dispatch of live undispatched op", {63'd0, rec_v[t]}, 64'd1);
            chk(rec_ak[t] && rec_bk[t], "R5 both sources known at dispatch", {62'd0, rec_ak[t], rec_bk[t]}, 64'd3);
            chk(disp_a == rec_ae[t] && disp_b == rec_be[t] && disp_op == rec_op[t], "R3 dispatched operands",
                {disp_a, disp_b}, {rec_ae[t], rec_be[t]});
            rec_disp[t] = 1;
            fp_v[(cyc + LAT) % 8] = 1;
            fp_t[(cyc + LAT) % 8] = disp_dst;
            fp_d[(cyc + LAT) % 8] = alu(disp_op, disp_a, disp_b);
        end
        accept = iss_valid && iss_ready && !flush;
        if (accept) begin
            t = int'(iss_dst);
            rec_v[t] = 1; rec_disp[t] = 0; rec_op[t] = iss_op;
            rec_ak[t] = iss_a_rdy; rec_ae[t] = iss_a_val; rec_at[t] = iss_a_tag;
            rec_bk[t] = iss_b_rdy; rec_be[t] = iss_b_val; rec_bt[t] = iss_b_tag;
            live[t] = 1; ext[t] = 0;
            occ++;
        end
        if (bus_valid && !flush) begin
            for (int k = 0; k < NT; k++) begin
                if (rec_v[k] && !rec_disp[k]) begin
                    if (!rec_ak[k] && rec_at[k] == bus_tag) begin rec_ak[k] = 1; rec_ae[k] = bus_val; end
                    if (!rec_bk[k] && rec_bt[k] == bus_tag) begin rec_bk[k] = 1; rec_be[k] = bus_val; end
                end
            end
            t = int'(bus_tag);
            if (rec_v[t] && rec_disp[t]) begin rec_v[t] = 0; occ--; end
            live[t] = 0; ext[t] = 0;
        end
        if (flush) clear_all();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        iss_valid = 0; bus_valid = 0; flush = 0;
        if (fp_v[cyc % 8]) begin
            bus_valid = 1; bus_tag = fp_t[cyc % 8]; bus_val = fp_d[cyc % 8];
            fp_v[cyc % 8] = 0;
        end
    endtask

    task automatic put(input int op, input int dst, input bit ar, input int av, input int at,
                       input bit br, input int bv, input int bt);
        iss_valid = 1; iss_op = OW'(op); iss_dst = TW'(dst);
        iss_a_rdy = ar; iss_a_val = DW'(av); iss_a_tag = TW'(at);
        iss_b_rdy = br; iss_b_val = DW'(bv); iss_b_tag = TW'(bt);
    endtask

    task automatic drain();
        int e;
        bit any_ext;
        forever begin
            any_ext = 0;
            for (int k = 0; k < NT; k++) if (ext[k]) any_ext = 1;
            if (occ == 0 && !any_ext) break;
            if (!bus_valid && any_ext) begin
                e = pend_tag(1);
                bus_valid = 1; bus_tag = TW'(e); bus_val = $urandom;
            end
            tick();
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int e;
        int d;
        void'($urandom(32'h5eed_0007));
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #2;
        chk(!disp_valid, "R1 reset no dispatch", {63'd0, disp_valid}, 64'd0);
        chk(iss_ready, "R1 reset all free", {63'd0, iss_ready}, 64'd1);

        // R2: reorder buffer full blocks issue
        rob_free = 0;
        put(0, 1, 1, 5, 0, 1, 6, 0);
        tick();
        chk(!disp_valid, "R2 nothing accepted while rob full", {63'd0, disp_valid}, 64'd0);
        rob_free = 1;

        // R6 / R3 / R9 / R7: four waiters released by one broadcast
        live[15] = 1; ext[15] = 1;
        for (int i = 0; i < NS; i++) begin
            put(i, i, 1, 100 + i, 0, 0, 0, 15);
            tick();
        end
        chk(!disp_valid, "R5 waiting sources hold dispatch", {63'd0, disp_valid}, 64'd0);
        chk(!iss_ready, "R9 four slots occupied", {63'd0, iss_ready}, 64'd0);
        bus_valid = 1; bus_tag = 15; bus_val = 32'h55;
        tick();
        chk(disp_valid && disp_slot == 0, "R6 lowest slot first", {62'd0, disp_slot}, 64'd0);
        chk(disp_b == 32'h55, "R3 captured bus value", disp_b, 64'h55);
        tick();
        chk(disp_valid && disp_slot == 1, "R6 second slot", {62'd0, disp_slot}, 64'd1);
        chk(!iss_ready, "R7 executing slot stays held", {63'd0, iss_ready}, 64'd0);
        tick();
        chk(disp_valid && disp_slot == 2, "R6 third slot", {62'd0, disp_slot}, 64'd2);
        tick();
        chk(disp_valid && disp_slot == 3, "R6 fourth slot", {62'd0, disp_slot}, 64'd3);
        drain();

        // R4: bus capture at issue
        live[14] = 1; ext[14] = 1;
        bus_valid = 1; bus_tag = 14; bus_val = 32'h1234;
        put(1, 5, 1, 7, 0, 0, 0, 14);
        tick();
        chk(disp_valid && disp_dst == 5, "R4 dispatch next cycle", {63'd0, disp_valid}, 64'd1);
        chk(disp_b == 32'h1234, "R4 value captured at issue", disp_b, 64'h1234);
        drain();

        // R5: held until last source arrives
        live[13] = 1; ext[13] = 1;
        put(2, 6, 0, 0, 13, 1, 9, 0);
        tick();
        for (int i = 0; i < 3; i++) begin
            chk(!disp_valid, "R5 held while source missing", {63'd0, disp_valid}, 64'd0);
            tick();
        end
        bus_valid = 1; bus_tag = 13; bus_val = 32'hABCD;
        tick();
        chk(disp_valid && disp_a == 32'hABCD, "R3 released after capture", disp_a, 64'hABCD);
        drain();

        // R8: flush
        live[12] = 1; ext[12] = 1;
        put(0, 2, 0, 0, 12, 1, 1, 0); tick();
        put(0, 3, 1, 1, 0, 0, 0, 12); tick();
        flush = 1;
        put(0, 9, 1, 3, 0, 1, 4, 0);
        tick();
        chk(!disp_valid, "R8 flushed issue not accepted", {63'd0, disp_valid}, 64'd0);
        chk(iss_ready, "R8 all slots empty", {63'd0, iss_ready}, 64'd1);
        bus_valid = 1; bus_tag = 12; bus_val = 32'h77;
        tick();
        chk(!disp_valid, "R8 flushed waiters gone", {63'd0, disp_valid}, 64'd0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 200 == 0) begin
                flush = 1; bus_valid = 0;
            end
            rob_free = ($urandom % 8) != 0;
            if (!bus_valid && $urandom % 4 == 0) begin
                e = pend_tag(1);
                if (e >= 0) begin bus_valid = 1; bus_tag = TW'(e); bus_val = $urandom; end
            end
            if (!flush && $urandom % 8 == 0) begin
                e = free_tag();
                if (e >= 0 && !(bus_valid && int'(bus_tag) == e)) begin live[e] = 1; ext[e] = 1; end
            end
            if ($urandom % 2 == 0) begin
                d = free_tag();
                if (d >= 0) begin
                    put(int'($urandom % 4), d, 1, int'($urandom), 0, 1, int'($urandom), 0);
                    if ($urandom % 2 == 0) begin
                        e = pend_tag(0);
                        if (e >= 0) begin iss_a_rdy = 0; iss_a_tag = TW'(e); end
                    end
                    if ($urandom % 2 == 0) begin
                        e = pend_tag(0);
                        if (e >= 0) begin iss_b_rdy = 0; iss_b_tag = TW'(e); end
                    end
                end
            end
            tick();
        end
        rob_free = 1;
        drain();
        tick();
        chk(iss_ready && !disp_valid, "R7 all slots freed after drain", {62'd0, iss_ready, disp_valid}, 64'd2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule